// File: doc/BRIEF.md
# Instruction Bundle Issue-Group Splitter

This block sits between instruction fetch and a narrow execution back end. It takes a stream of 128-bit bundles. Each bundle carries three 41-bit operation slots and a 5-bit template. The template's stop code marks where a group of mutually independent operations ends. The block releases operations in program order, at most `W` per cycle. It never lets two groups share a cycle, and it flags the cycle that carries the last operation of each group.

A group that is not closed inside a bundle carries on into the following bundle. A group wider than the back end is spread over as many cycles as it needs. The issue width `W` is a parameter. The order of operations and the group boundaries are the same for every width; only the number of cycles changes.

Bundles arrive over a valid/ready handshake into a single holding register. The register can be refilled in the same cycle that its last slot leaves.

Top module: `bundle_group_splitter`

## Requirements
- R1: Template field is `in_bundle[4:0]`. Slot 0 is `in_bundle[45:5]`, slot 1 is `in_bundle[86:46]` and slot 2 is `in_bundle[127:87]`. All three slots of every accepted bundle are issued exactly once, in the order slot 0, slot 1, slot 2, and bundle by bundle in acceptance order.
- R2: The stop code is `in_bundle[1:0]`: 0 means no stop, 1 means a stop after slot 0, 2 a stop after slot 1, and 3 a stop after slot 2. Template bits [4:2] have no effect on the output.
- R3: `out_eog` is high exactly in the cycles whose last issued operation is the slot just before a stop. A group with no stop in its bundle continues into the next bundle, with `out_eog` low.
- R4: At most min(W,3) operations issue per cycle. With input always valid, the bundles issue with no idle cycle between them. Each stop-delimited piece of a bundle takes ceil(length/W) cycles.
- R5: An operation that closes a group is always the last operation of its cycle. The next group starts in a later cycle.
- R6: Valid operations occupy lanes 0 upward in program order, so `out_valid` is a contiguous run of low bits. Lanes that are not valid carry all-zero operation bits.
- R7: `in_ready` is high when no bundle is held, or when the held bundle issues its final slot this cycle. It is low otherwise. A bundle is taken at a rising clock edge where `in_valid` and `in_ready` are both high.
- R8: While reset is low and after it is released, no lane is valid, `out_eog` is low and `in_ready` is high until a bundle has been accepted.
- R9: For widths 2 and 4, the issued operation sequence and the group boundaries are identical for the same input bundles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Bundle on `in_bundle` is offered |
| in_ready | output | 1 | Block takes the offered bundle at the next edge |
| in_bundle | input | 128 | Template and three operation slots |
| out_valid | output | W | Per-lane issue valid |
| out_op | output | W*41 | Lane l operation in bits [l*41 +: 41] |
| out_eog | output | 1 | This cycle closes an issue group |

## Verification
The bound checker watches the following on every cycle:
- `out_valid` stays packed into the low lanes.
- The issue count stays within the width limit.
- Every held bundle issues at least one operation per cycle.
- Exactly three operations leave between a bundle's acceptance and its final slot.
- The end-of-group flag always comes with an issued operation.
- The block is ready and silent whenever it is empty.

Only the bench's scenarios can show whether the right slot reaches the right lane, whether stop codes close groups at the correct slot and span bundles when absent, and whether the upper template bits are ignored. They also show that cycle counts per bundle match the width, and that two widths produce the same operation and boundary stream.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int SLOTS    = 3;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int CODE_W   = 2;
  localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [2:0]        pos_t;

  // Encoded value equals one plus the slot that closes the group.
  typedef enum logic [CODE_W-1:0] {
    STOP_NONE     = 2'd0,
    STOP_AFTER_S0 = 2'd1,
    STOP_AFTER_S1 = 2'd2,
    STOP_AFTER_S2 = 2'd3
  } stop_e;

  // First slot index that lies beyond the current group segment.
  function automatic pos_t seg_limit(stop_e s, pos_t idx);
    pos_t bound;
    bound = {1'b0, s};
    if (s == STOP_NONE) return pos_t'(SLOTS);
    if (bound > idx)    return bound;
    return pos_t'(SLOTS);
  endfunction

  // Operations that may leave this cycle: the rest of the segment, capped by width.
  function automatic pos_t chunk_len(pos_t lim, pos_t idx, pos_t cap);
    pos_t avail;
    avail = lim - idx;
    return (avail > cap) ? cap : avail;
  endfunction
endpackage

// File: rtl/bgs_tmpl_decode.sv
module bgs_tmpl_decode
  import bgs_pkg::*;
(
  input  logic [BUNDLE_W-1:0]           bundle,
  output stop_e                         stop,
  output logic [SLOTS-1:0][SLOT_W-1:0]  slots
);
  assign stop = stop_e'(bundle[CODE_W-1:0]);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slots[k] = bundle[TMPL_W + k*SLOT_W +: SLOT_W];
  end

  // Upper template bits carry no meaning for issue grouping.
  logic unused_tmpl;
  assign unused_tmpl = ^bundle[TMPL_W-1:CODE_W];
endmodule

// File: rtl/bgs_slot_buffer.sv
module bgs_slot_buffer
  import bgs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [SLOTS-1:0][SLOT_W-1:0]  slots_in,
  input  stop_e                         stop_in,
  input  pos_t                          step,
  output logic                          held,
  output logic [SLOTS-1:0][SLOT_W-1:0]  slots_q,
  output stop_e                         stop_q,
  output pos_t                          idx_q
);
  pos_t idx_nxt;
  assign idx_nxt = idx_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      idx_q   <= '0;
      stop_q  <= STOP_NONE;
      slots_q <= '0;
    end else if (load) begin
      held    <= 1'b1;
      idx_q   <= '0;
      stop_q  <= stop_in;
      slots_q <= slots_in;
    end else if (held) begin
      idx_q <= idx_nxt;
      if (idx_nxt == pos_t'(SLOTS)) held <= 1'b0;
    end
  end
endmodule

// File: rtl/bgs_lane_select.sv
module bgs_lane_select
  import bgs_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [SLOTS-1:0][SLOT_W-1:0]  slots,
  input  pos_t                          idx,
  input  pos_t                          count,
  output logic [W-1:0]                  lane_v,
  output logic [W-1:0][SLOT_W-1:0]      lane_op
);
  for (genvar l = 0; l < W; l++) begin : g_lane
    if (l < SLOTS) begin : g_live
      localparam pos_t LN = pos_t'(l);
      pos_t src;
      assign src        = idx + LN;
      assign lane_v[l]  = (LN < count);
      assign lane_op[l] = (lane_v[l] && (src < pos_t'(SLOTS))) ? slots[src[1:0]] : '0;
    end else begin : g_dead
      assign lane_v[l]  = 1'b0;
      assign lane_op[l] = '0;
    end
  end
endmodule

// File: rtl/bundle_group_splitter.sv
module bundle_group_splitter
  import bgs_pkg::*;
#(
  parameter int W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUNDLE_W-1:0]  in_bundle,
  output logic [W-1:0]         out_valid,
  output logic [W*SLOT_W-1:0]  out_op,
  output logic                 out_eog
);
  localparam pos_t W_CAP = (W >= SLOTS) ? pos_t'(SLOTS) : pos_t'(W);

  // Named internal events, also observed by the bound checker.
  stop_e                        dec_stop;
  logic [SLOTS-1:0][SLOT_W-1:0] dec_slots;
  logic                         load;
  logic                         held;
  logic [SLOTS-1:0][SLOT_W-1:0] slots_q;
  stop_e                        stop_q;
  pos_t                         idx_q;
  pos_t                         seg_end;
  pos_t                         step;
  pos_t                         idx_after;
  logic                         bundle_done;
  logic [W-1:0][SLOT_W-1:0]     lane_op;

  bgs_tmpl_decode u_dec (
    .bundle (in_bundle),
    .stop   (dec_stop),
    .slots  (dec_slots)
  );

  assign seg_end     = seg_limit(stop_q, idx_q);
  assign step        = held ? chunk_len(seg_end, idx_q, W_CAP) : '0;
  assign idx_after   = idx_q + step;
  assign bundle_done = held && (idx_after == pos_t'(SLOTS));
  assign in_ready    = !held || bundle_done;
  assign load        = in_valid && in_ready;
  assign out_eog     = held && (stop_q != STOP_NONE) && (idx_after == {1'b0, stop_q});

  bgs_slot_buffer u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .slots_in (dec_slots),
    .stop_in  (dec_stop),
    .step     (step),
    .held     (held),
    .slots_q  (slots_q),
    .stop_q   (stop_q),
    .idx_q    (idx_q)
  );

  bgs_lane_select #(.W(W)) u_lanes (
    .slots   (slots_q),
    .idx     (idx_q),
    .count   (step),
    .lane_v  (out_valid),
    .lane_op (lane_op)
  );

  assign out_op = lane_op;
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker
  import bgs_pkg::*;
#(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         held,
  input logic         bundle_done,
  input logic         out_eog,
  input logic [W-1:0] out_valid
);
  localparam logic [3:0] W_LIM = (W > SLOTS) ? 4'(SLOTS) : 4'(W);

  logic [3:0] nvalid;
  logic [3:0] issued_q;

  always_comb begin
    nvalid = '0;
    for (int l = 0; l < W; l++) nvalid = nvalid + {3'b000, out_valid[l]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    issued_q <= '0;
    else if (in_valid && in_ready) issued_q <= '0;
    else if (held)                 issued_q <= issued_q + nvalid;
  end

  p_bundle_complete_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_done |-> (issued_q + nvalid == 4'd3));

  p_width_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (nvalid != 4'd0 && nvalid <= W_LIM));

  p_eog_has_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eog |-> out_valid[0]);

  p_lanes_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & W'(out_valid + 1'b1)) == '0);

  p_ready_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> in_ready);

  p_accept_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> held);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> (out_valid == '0 && !out_eog));
endmodule

bind bundle_group_splitter bgs_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .held        (held),
  .bundle_done (bundle_done),
  .out_eog     (out_eog),
  .out_valid   (out_valid)
);

// File: tb/bundle_group_splitter_tb_top.sv
`timescale 1ns/1ps
module bundle_group_splitter_tb_top;
  localparam int SW = 41;
  localparam int NB = 12;
  localparam int NOPS = NB * 3;

  typedef struct packed {
    logic [4:0] tmpl;
    logic [3:0] cyc_w2;
    logic [3:0] cyc_w4;
  } vec_t;

  // template, cycles on width 2, cycles on width 4
  localparam vec_t TAB [NB] = '{
    '{5'b00011, 4'd2, 4'd1},
    '{5'b00000, 4'd2, 4'd1},
    '{5'b11101, 4'd2, 4'd2},
    '{5'b00010, 4'd2, 4'd2},
    '{5'b10100, 4'd2, 4'd1},
    '{5'b00000, 4'd2, 4'd1},
    '{5'b01011, 4'd2, 4'd1},
    '{5'b00001, 4'd2, 4'd2},
    '{5'b00001, 4'd2, 4'd2},
    '{5'b11110, 4'd2, 4'd2},
    '{5'b00000, 4'd2, 4'd1},
    '{5'b00011, 4'd2, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           a_in_v = 1'b0, b_in_v = 1'b0;
  logic [127:0]   a_bundle = '0, b_bundle = '0;
  logic           a_ready, b_ready, a_eog, b_eog;
  logic [1:0]     a_v;
  logic [3:0]     b_v;
  logic [2*SW-1:0] a_op;
  logic [4*SW-1:0] b_op;

  bundle_group_splitter #(.W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(a_in_v), .in_ready(a_ready), .in_bundle(a_bundle),
    .out_valid(a_v), .out_op(a_op), .out_eog(a_eog));

  bundle_group_splitter #(.W(4)) dut_w4 (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_v), .in_ready(b_ready), .in_bundle(b_bundle),
    .out_valid(b_v), .out_op(b_op), .out_eog(b_eog));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  int ptr_a = 0, ptr_b = 0;
  int first_a = -1, last_a = -1, first_b = -1, last_b = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] op_of(input int b, input int s);
    return SW'(64'h1_5000_0000 + 64'(b) * 8 + 64'(s));
  endfunction

  function automatic logic [127:0] mk(input int b, input logic [4:0] t);
    logic [127:0] r;
    r = '0;
    r[4:0]    = t;
    r[5 +: SW]  = op_of(b, 0);
    r[46 +: SW] = op_of(b, 1);
    r[87 +: SW] = op_of(b, 2);
    return r;
  endfunction

  // R2 encoding: code c closes the group after slot c-1.
  function automatic bit closes(input int j);
    int code;
    code = int'(TAB[j / 3].tmpl[1:0]);
    return (code != 0) && ((j % 3) == code - 1);
  endfunction

  task automatic observe(input int w, input logic [3:0] v, input logic [4*SW-1:0] ops,
                         input logic eog, inout int ptr, inout int first_c, inout int last_c);
    int n;
    bit gap;
    bit last_close;
    n = 0; gap = 1'b0; last_close = 1'b0;
    for (int l = 0; l < 4; l++) begin
      if (l >= w) begin
        check(v[l] == 1'b0, "R4 lane beyond width", 64'(v[l]), 64'd0);
      end else if (v[l]) begin
        check(!gap, "R6 valid lane after idle lane", 64'(v), 64'd0);
        check(ptr < NOPS, "R1 extra operation", 64'(ptr), 64'(NOPS));
        check(ops[l*SW +: SW] == op_of(ptr / 3, ptr % 3), "R1 slot order",
              64'(ops[l*SW +: SW]), 64'(op_of(ptr / 3, ptr % 3)));
        check(!last_close, "R5 op after group end in same cycle", 64'(ptr), 64'd0);
        last_close = closes(ptr);
        ptr++;
        n++;
      end else begin
        gap = 1'b1;
        check(ops[l*SW +: SW] == '0, "R6 idle lane nonzero", 64'(ops[l*SW +: SW]), 64'd0);
      end
    end
    check(eog == last_close, "R3 end-of-group flag", 64'(eog), 64'(last_close));
    if (n > 0) begin
      if (first_c < 0) first_c = cyc;
      last_c = cyc;
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (|a_v || a_eog) observe(2, {2'b00, a_v}, {{(2*SW){1'b0}}, a_op}, a_eog, ptr_a, first_a, last_a);
      if (|b_v || b_eog) observe(4, b_v, b_op, b_eog, ptr_b, first_b, last_b);
    end
  end

  task automatic drive_a();
    for (int b = 0; b < NB; b++) begin
      a_bundle = mk(b, TAB[b].tmpl);
      a_in_v = 1'b1;
      while (!a_ready) @(negedge clk);
      @(negedge clk);
    end
    a_in_v = 1'b0;
  endtask

  task automatic drive_b();
    for (int b = 0; b < NB; b++) begin
      b_bundle = mk(b, TAB[b].tmpl);
      b_in_v = 1'b1;
      while (!b_ready) @(negedge clk);
      @(negedge clk);
    end
    b_in_v = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sum2;
    int sum4;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(a_v == '0 && !a_eog, "R8 lanes idle in reset", 64'(a_v), 64'd0);
    check(a_ready, "R8 ready in reset", 64'(a_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(a_v == '0 && b_v == '0 && !a_eog && !b_eog, "R8 idle after reset", 64'({a_v, b_v}), 64'd0);
    check(a_ready && b_ready, "R8 ready after reset", 64'({a_ready, b_ready}), 64'h3);

    // Table walk on both widths (R1..R6, R9)
    mon_en = 1'b1;
    fork
      drive_a();
      drive_b();
    join
    repeat (6) @(negedge clk);
    mon_en = 1'b0;

    sum2 = 0; sum4 = 0;
    for (int b = 0; b < NB; b++) begin
      sum2 += int'(TAB[b].cyc_w2);
      sum4 += int'(TAB[b].cyc_w4);
    end
    check(ptr_a == NOPS, "R1 all ops issued width 2", 64'(ptr_a), 64'(NOPS));
    check(ptr_b == NOPS, "R9 same op stream width 4", 64'(ptr_b), 64'(NOPS));
    check(last_a - first_a + 1 == sum2, "R4 cycle span width 2", 64'(last_a - first_a + 1), 64'(sum2));
    check(last_b - first_b + 1 == sum4, "R4 cycle span width 4", 64'(last_b - first_b + 1), 64'(sum4));

    // R7 handshake on width 2, bundle with no stop (R3 open group)
    a_bundle = mk(20, 5'b00000);
    a_in_v = 1'b1;
    check(a_ready, "R7 ready while empty", 64'(a_ready), 64'd1);
    @(negedge clk);
    a_in_v = 1'b0;
    check(a_v == 2'b11, "R4 first two slots", 64'(a_v), 64'h3);
    check(a_op == {op_of(20, 1), op_of(20, 0)}, "R1 lane contents", 64'(a_op[SW-1:0]), 64'(op_of(20, 0)));
    check(!a_ready, "R7 not ready with slots left", 64'(a_ready), 64'd0);
    check(!a_eog, "R3 open group no flag", 64'(a_eog), 64'd0);
    @(negedge clk);
    check(a_v == 2'b01, "R6 single op on lane 0", 64'(a_v), 64'h1);
    check(a_op[SW-1:0] == op_of(20, 2), "R1 last slot", 64'(a_op[SW-1:0]), 64'(op_of(20, 2)));
    check(a_op[2*SW-1:SW] == '0, "R6 idle lane zero", 64'(a_op[2*SW-1:SW]), 64'd0);
    check(a_ready, "R7 ready on final slot", 64'(a_ready), 64'd1);
    check(!a_eog, "R3 group still open at bundle end", 64'(a_eog), 64'd0);
    @(negedge clk);
    check(a_v == '0 && a_ready, "R7 empty after drain", 64'({a_v, a_ready}), 64'h1);

    // R2: stop code 2 with upper template bits set, then closed after slot 1
    a_bundle = mk(21, 5'b10110);
    a_in_v = 1'b1;
    @(negedge clk);
    a_in_v = 1'b0;
    check(a_v == 2'b11 && a_eog, "R2 stop after slot 1", 64'({a_v, a_eog}), 64'h7);
    @(negedge clk);
    check(a_v == 2'b01 && !a_eog, "R5 next group starts new cycle", 64'({a_v, a_eog}), 64'h2);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule